// File: doc/BRIEF.md
# Exception Entry and Status Register Controller

This block holds the processor's current status word and sequences every change of processor state around exceptions. Seven request lines can ask for an exception: reset, undefined instruction, software interrupt, instruction-fetch abort, data abort, normal interrupt and fast interrupt. The block picks the winner and updates the status word in one step. In the same step it emits the handler address, together with write strobes that place the return address and the previous status word into the banked registers of the target mode. The register bank itself lives outside this block.

The block also performs the exception return, which restores the status word from a supplied saved copy and reloads the PC from a supplied link value. It carries out software writes to the status word as well. Each such write has a four-bit byte-lane mask, and a write made in user mode can change only the top byte. A configuration input moves the handler table from address zero to a high base.

Top module: `psr_exc_unit`

## Requirements
- R1: After reset the status word reads 0x000000D3: mode 5'h13 (supervisor), I (bit 7) and F (bit 6) set, and T (bit 5), J (bit 24) and the flags (bits 31:27) clear. No strobe is high.
- R2: On entry the PC output is the base plus the exception offset. The base is 0 when `hiVec` is 0 and 0xFFFF0000 when it is 1. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, fetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: The target modes use these encodings: reset and software interrupt go to supervisor (5'h13), both aborts go to abort (5'h17), undefined goes to undefined (5'h1B), the normal interrupt goes to 5'h12 and the fast interrupt goes to 5'h11. User mode is 5'h10.
- R4: On entry the new status word keeps all bits of the old one except these: the mode field takes the target mode, T and J are cleared, and I is set. F is also set, but only for reset and the fast interrupt.
- R5: On entry `lrWe` and `spsrWe` pulse together. `lrData` carries `retAddr`, `spsrData` carries the status word held before entry, and both mode tags carry the target mode.
- R6: When several requests are active in the same cycle, the priority runs from highest to lowest: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined, software interrupt.
- R7: A normal-interrupt request has no effect while I is set, and a fast-interrupt request has no effect while F is set. A lower-priority request can then be taken instead.
- R8: A return request loads the status word from `retSpsr` and drives the PC output with `retLr`, and it writes no banked register. An exception in the same cycle takes precedence over the return.
- R9: In a privileged mode, a status write changes exactly the bytes whose mask bit is set. Mask bit 3 selects bits 31:24, bit 2 selects bits 23:16, bit 1 selects bits 15:8 and bit 0 selects bits 7:0.
- R10: In user mode, a status write can change only bits 31:24. The other mask bits are ignored.
- R11: A status write has no effect in a cycle that also takes an exception or a return.
- R12: All results appear at the outputs one clock after the request is sampled. `pcLoad`, `lrWe` and `spsrWe` stay high for that single cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqRst | input | 1 | Reset exception request |
| reqUnd | input | 1 | Undefined-instruction request |
| reqSwi | input | 1 | Software-interrupt request |
| reqPabt | input | 1 | Instruction-fetch abort request |
| reqDabt | input | 1 | Data abort request |
| reqIrq | input | 1 | Normal interrupt request |
| reqFiq | input | 1 | Fast interrupt request |
| hiVec | input | 1 | Select the high handler base |
| retAddr | input | 32 | Return address to bank on entry |
| retReq | input | 1 | Exception return request |
| retSpsr | input | 32 | Saved status word to restore |
| retLr | input | 32 | Link value to restore into the PC |
| wrEn | input | 1 | Status word write request |
| wrMask | input | 4 | Byte-lane mask of the write |
| wrData | input | 32 | Status word write data |
| psr | output | 32 | Current status word |
| pcLoad | output | 1 | PC redirect strobe |
| pcValue | output | 32 | New PC value |
| lrWe | output | 1 | Banked link register write strobe |
| lrMode | output | 5 | Target mode of the link write |
| lrData | output | 32 | Link register write data |
| spsrWe | output | 1 | Saved status write strobe |
| spsrMode | output | 5 | Target mode of the saved status write |
| spsrData | output | 32 | Saved status write data |

## Verification
A wrong priority choice or a wrong interrupt mask shows up one clock after the request. It appears at once as a wrong `pcValue` offset and a wrong mode tag on the banked writes. A corrupted status word shows up in the same cycle on `psr`, and it shows up again on `spsrData` at the next entry. The sweeps cover every combination of the seven request lines under each setting of I and F and both handler bases. The byte-lane mask is swept over all sixteen values in both privileged and user mode, so a lane error appears on `psr` immediately after the write.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;
  localparam int PsrW = 32;

  localparam int BitT = 5;
  localparam int BitF = 6;
  localparam int BitI = 7;
  localparam int BitJ = 24;

  localparam logic [4:0] ModeUsr = 5'h10;
  localparam logic [4:0] ModeFiq = 5'h11;
  localparam logic [4:0] ModeIrq = 5'h12;
  localparam logic [4:0] ModeSvc = 5'h13;
  localparam logic [4:0] ModeAbt = 5'h17;
  localparam logic [4:0] ModeUnd = 5'h1B;

  localparam logic [PsrW-1:0] ResetPsr = 32'h0000_00D3;

  // Encoding doubles as the table slot: offset = kind * 4; slot 5 is unused.
  typedef enum logic [2:0] {
    EX_RST  = 3'd0,
    EX_UND  = 3'd1,
    EX_SWI  = 3'd2,
    EX_PABT = 3'd3,
    EX_DABT = 3'd4,
    EX_IRQ  = 3'd6,
    EX_FIQ  = 3'd7
  } excKind_e;

  typedef struct packed {
    logic       enter;
    excKind_e   kind;
    logic       doRet;
    logic       doWr;
    logic [3:0] laneMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/psr_ctrl.sv
`timescale 1ns/1ps
module psr_ctrl
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqRst,
  input  logic        reqUnd,
  input  logic        reqSwi,
  input  logic        reqPabt,
  input  logic        reqDabt,
  input  logic        reqIrq,
  input  logic        reqFiq,
  input  logic        retReq,
  input  logic        wrEn,
  input  logic [3:0]  wrMask,
  input  logic [4:0]  curMode,
  input  logic        maskI,
  input  logic        maskF,
  output ctrlStrobe_t strobe
);
  logic privileged;
  assign privileged = (curMode != ModeUsr);

  always_comb begin
    strobe = '0;
    if (reqRst) begin
      strobe.enter = 1'b1; strobe.kind = EX_RST;
    end else if (reqDabt) begin
      strobe.enter = 1'b1; strobe.kind = EX_DABT;
    end else if (reqFiq && !maskF) begin
      strobe.enter = 1'b1; strobe.kind = EX_FIQ;
    end else if (reqIrq && !maskI) begin
      strobe.enter = 1'b1; strobe.kind = EX_IRQ;
    end else if (reqPabt) begin
      strobe.enter = 1'b1; strobe.kind = EX_PABT;
    end else if (reqUnd) begin
      strobe.enter = 1'b1; strobe.kind = EX_UND;
    end else if (reqSwi) begin
      strobe.enter = 1'b1; strobe.kind = EX_SWI;
    end else if (retReq) begin
      strobe.doRet = 1'b1;
    end else if (wrEn) begin
      strobe.doWr     = 1'b1;
      strobe.laneMask = privileged ? wrMask : {wrMask[3], 3'b000};
    end
  end

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskI && strobe.enter) |-> (strobe.kind != EX_IRQ));

  assert_fiq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskF && strobe.enter) |-> (strobe.kind != EX_FIQ));

  assert_single_action_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.enter, strobe.doRet, strobe.doWr}));

  assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqRst |-> (strobe.enter && strobe.kind == EX_RST));

  assert_user_lanes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doWr && curMode == ModeUsr) |-> (strobe.laneMask[2:0] == 3'b000));
endmodule

// File: rtl/psr_datapath.sv
`timescale 1ns/1ps
module psr_datapath
  import psr_pkg::*;
#(
  parameter int              AddrW  = 32,
  parameter logic [AddrW-1:0] HiBase = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             hiVec,
  input  logic [AddrW-1:0] retAddr,
  input  logic [PsrW-1:0]  retSpsr,
  input  logic [AddrW-1:0] retLr,
  input  logic [PsrW-1:0]  wrData,
  output logic [PsrW-1:0]  psr,
  output logic             pcLoad,
  output logic [AddrW-1:0] pcValue,
  output logic             lrWe,
  output logic [4:0]       lrMode,
  output logic [AddrW-1:0] lrData,
  output logic             spsrWe,
  output logic [4:0]       spsrMode,
  output logic [PsrW-1:0]  spsrData
);
  localparam int Lanes = PsrW / 8;

  logic [4:0]       targetMode;
  logic [AddrW-1:0] vecAddr;
  logic [PsrW-1:0]  entryPsr;
  logic [PsrW-1:0]  wrPsr;

  always_comb begin
    unique case (strobe.kind)
      EX_FIQ:          targetMode = ModeFiq;
      EX_IRQ:          targetMode = ModeIrq;
      EX_PABT, EX_DABT: targetMode = ModeAbt;
      EX_UND:          targetMode = ModeUnd;
      default:         targetMode = ModeSvc;
    endcase
  end

  assign vecAddr = (hiVec ? HiBase : '0) | {{(AddrW-5){1'b0}}, strobe.kind, 2'b00};

  always_comb begin
    entryPsr       = psr;
    entryPsr[4:0]  = targetMode;
    entryPsr[BitT] = 1'b0;
    entryPsr[BitJ] = 1'b0;
    entryPsr[BitI] = 1'b1;
    if (strobe.kind == EX_RST || strobe.kind == EX_FIQ) entryPsr[BitF] = 1'b1;
  end

  for (genvar lane = 0; lane < Lanes; lane++) begin : g_lane
    assign wrPsr[lane*8 +: 8] = strobe.laneMask[lane] ? wrData[lane*8 +: 8]
                                                      : psr[lane*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psr      <= ResetPsr;
      pcLoad   <= 1'b0;
      pcValue  <= '0;
      lrWe     <= 1'b0;
      lrMode   <= ModeSvc;
      lrData   <= '0;
      spsrWe   <= 1'b0;
      spsrMode <= ModeSvc;
      spsrData <= '0;
    end else begin
      pcLoad <= 1'b0;
      lrWe   <= 1'b0;
      spsrWe <= 1'b0;
      if (strobe.enter) begin
        psr      <= entryPsr;
        pcLoad   <= 1'b1;
        pcValue  <= vecAddr;
        lrWe     <= 1'b1;
        lrMode   <= targetMode;
        lrData   <= retAddr;
        spsrWe   <= 1'b1;
        spsrMode <= targetMode;
        spsrData <= psr;
      end else if (strobe.doRet) begin
        psr     <= retSpsr;
        pcLoad  <= 1'b1;
        pcValue <= retLr;
      end else if (strobe.doWr) begin
        psr <= wrPsr;
      end
    end
  end

  assert_entry_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    lrWe |-> (!psr[BitT] && !psr[BitJ] && psr[BitI] && psr[4:0] == lrMode));

  assert_spsr_prior_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spsrWe) |-> (spsrData == $past(psr)));

  assert_bank_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lrWe == spsrWe) && (!lrWe || lrMode == spsrMode));

  assert_vector_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
    lrWe |-> (pcValue[1:0] == 2'b00 && pcValue[4:2] != 3'd5 && pcLoad));
endmodule

// File: rtl/psr_exc_unit.sv
`timescale 1ns/1ps
module psr_exc_unit
  import psr_pkg::*;
#(
  parameter int              AddrW  = 32,
  parameter logic [AddrW-1:0] HiBase = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqRst,
  input  logic             reqUnd,
  input  logic             reqSwi,
  input  logic             reqPabt,
  input  logic             reqDabt,
  input  logic             reqIrq,
  input  logic             reqFiq,
  input  logic             hiVec,
  input  logic [AddrW-1:0] retAddr,
  input  logic             retReq,
  input  logic [31:0]      retSpsr,
  input  logic [AddrW-1:0] retLr,
  input  logic             wrEn,
  input  logic [3:0]       wrMask,
  input  logic [31:0]      wrData,
  output logic [31:0]      psr,
  output logic             pcLoad,
  output logic [AddrW-1:0] pcValue,
  output logic             lrWe,
  output logic [4:0]       lrMode,
  output logic [AddrW-1:0] lrData,
  output logic             spsrWe,
  output logic [4:0]       spsrMode,
  output logic [31:0]      spsrData
);
  ctrlStrobe_t strobe;

  psr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqRst  (reqRst),
    .reqUnd  (reqUnd),
    .reqSwi  (reqSwi),
    .reqPabt (reqPabt),
    .reqDabt (reqDabt),
    .reqIrq  (reqIrq),
    .reqFiq  (reqFiq),
    .retReq  (retReq),
    .wrEn    (wrEn),
    .wrMask  (wrMask),
    .curMode (psr[4:0]),
    .maskI   (psr[BitI]),
    .maskF   (psr[BitF]),
    .strobe  (strobe)
  );

  psr_datapath #(.AddrW(AddrW), .HiBase(HiBase)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hiVec    (hiVec),
    .retAddr  (retAddr),
    .retSpsr  (retSpsr),
    .retLr    (retLr),
    .wrData   (wrData),
    .psr      (psr),
    .pcLoad   (pcLoad),
    .pcValue  (pcValue),
    .lrWe     (lrWe),
    .lrMode   (lrMode),
    .lrData   (lrData),
    .spsrWe   (spsrWe),
    .spsrMode (spsrMode),
    .spsrData (spsrData)
  );
endmodule

// File: tb/psr_exc_unit_tb.sv
`timescale 1ns/1ps
module psr_exc_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqRst = 0, reqUnd = 0, reqSwi = 0, reqPabt = 0, reqDabt = 0, reqIrq = 0, reqFiq = 0;
  logic        hiVec = 0;
  logic [31:0] retAddr = 0;
  logic        retReq = 0;
  logic [31:0] retSpsr = 0;
  logic [31:0] retLr = 0;
  logic        wrEn = 0;
  logic [3:0]  wrMask = 0;
  logic [31:0] wrData = 0;
  logic [31:0] psr, pcValue, lrData, spsrData;
  logic        pcLoad, lrWe, spsrWe;
  logic [4:0]  lrMode, spsrMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psr_exc_unit u_dut (
    .clk(clk), .rstN(rstN), .reqRst(reqRst), .reqUnd(reqUnd), .reqSwi(reqSwi),
    .reqPabt(reqPabt), .reqDabt(reqDabt), .reqIrq(reqIrq), .reqFiq(reqFiq),
    .hiVec(hiVec), .retAddr(retAddr), .retReq(retReq), .retSpsr(retSpsr),
    .retLr(retLr), .wrEn(wrEn), .wrMask(wrMask), .wrData(wrData), .psr(psr),
    .pcLoad(pcLoad), .pcValue(pcValue), .lrWe(lrWe), .lrMode(lrMode),
    .lrData(lrData), .spsrWe(spsrWe), .spsrMode(spsrMode), .spsrData(spsrData)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // r bits: 0 rst, 1 und, 2 swi, 3 pabt, 4 dabt, 5 irq, 6 fiq. Returns slot or -1.
  function automatic int pickSlot(logic [6:0] r, logic iBit, logic fBit);
    if (r[0]) return 0;
    if (r[4]) return 4;
    if (r[6] && !fBit) return 7;
    if (r[5] && !iBit) return 6;
    if (r[3]) return 3;
    if (r[1]) return 1;
    if (r[2]) return 2;
    return -1;
  endfunction

  function automatic logic [4:0] modeOf(int slot);
    case (slot)
      7: return 5'h11;
      6: return 5'h12;
      3, 4: return 5'h17;
      1: return 5'h1B;
      default: return 5'h13;
    endcase
  endfunction

  task automatic doWrite(logic [3:0] m, logic [31:0] d);
    @(negedge clk); wrEn = 1; wrMask = m; wrData = d;
    @(negedge clk); wrEn = 0; wrMask = 0; wrData = 0;
  endtask

  task automatic setReqs(logic [6:0] r);
    {reqFiq, reqIrq, reqDabt, reqPabt, reqSwi, reqUnd, reqRst} = r;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 psr", psr, 32'h0000_00D3);
    chk("R1 strobes", {29'd0, pcLoad, lrWe, spsrWe}, 32'd0);

    // Sweep R2 R3 R4 R5 R6 R7: all request combos, I/F settings, both bases
    for (int ifs = 0; ifs < 4; ifs++) begin
      for (int hv = 0; hv < 2; hv++) begin
        for (int r = 0; r < 128; r++) begin
          logic [31:0] base, expPsr, expPc;
          int slot;
          base = 32'h5100_0033 | (32'(ifs) << 6);
          doWrite(4'hF, base);
          chk("R9 full write", psr, base);
          slot = pickSlot(7'(r), base[7], base[6]);
          @(negedge clk);
          setReqs(7'(r)); hiVec = 1'(hv); retAddr = 32'h1000_0000 + 32'(r * 4);
          @(negedge clk);
          setReqs(7'd0);
          if (slot < 0) begin
            chk("R7 no entry", {31'd0, pcLoad}, 32'd0);
            chk("R7 psr kept", psr, base);
          end else begin
            expPc = (hv != 0 ? 32'hFFFF_0000 : 32'h0) + 32'(slot * 4);
            expPsr = {base[31:25], 1'b0, base[23:8], 1'b1,
                      (slot == 0 || slot == 7) ? 1'b1 : base[6], 1'b0, modeOf(slot)};
            chk("R2 R6 vector", pcValue, expPc);
            chk("R3 lr mode", {27'd0, lrMode}, {27'd0, modeOf(slot)});
            chk("R4 psr", psr, expPsr);
            chk("R5 lr data", lrData, retAddr);
            chk("R5 spsr data", spsrData, base);
            chk("R5 strobes", {29'd0, pcLoad, lrWe, spsrWe}, 32'd7);
            chk("R5 spsr mode", {27'd0, spsrMode}, {27'd0, modeOf(slot)});
            @(negedge clk);
            chk("R12 single pulse", {29'd0, pcLoad, lrWe, spsrWe}, 32'd0);
          end
        end
      end
    end
    hiVec = 0;

    // R9 privileged lane sweep
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d, e;
      doWrite(4'hF, 32'h0000_00D3);
      d = 32'h5AC3_3CD3;
      e = 32'h0000_00D3;
      for (int b = 0; b < 4; b++) if (m[b]) e[b*8 +: 8] = d[b*8 +: 8];
      doWrite(4'(m), d);
      chk("R9 lane write", psr, e);
    end

    // R10 user mode lane sweep
    for (int m = 0; m < 16; m++) begin
      doWrite(4'hF, 32'h0000_0010);
      chk("R10 enter user", psr, 32'h0000_0010);
      doWrite(4'(m), 32'hFFFF_FFFF);
      chk("R10 user write", psr, (m >= 8) ? 32'hFF00_0010 : 32'h0000_0010);
      @(negedge clk); reqSwi = 1;
      @(negedge clk); reqSwi = 0;
      chk("R3 swi from user", psr[4:0], 5'h13);
    end

    // R8 return
    doWrite(4'hF, 32'h0000_00D3);
    @(negedge clk); retReq = 1; retSpsr = 32'hA000_0010; retLr = 32'h0000_8124;
    wrEn = 1; wrMask = 4'hF; wrData = 32'h1234_5678;
    @(negedge clk); retReq = 0; wrEn = 0; wrMask = 0;
    chk("R8 psr restored", psr, 32'hA000_0010);
    chk("R8 pc", pcValue, 32'h0000_8124);
    chk("R8 no bank write", {30'd0, pcLoad, lrWe | spsrWe}, 32'd2);
    chk("R11 write dropped on return", psr, 32'hA000_0010);

    // R8 exception beats return; R11 write dropped on entry
    @(negedge clk); retReq = 1; retSpsr = 32'h0000_0010; retLr = 32'h4;
    reqUnd = 1; retAddr = 32'h0000_0300; wrEn = 1; wrMask = 4'h8; wrData = 32'h0F00_0000;
    @(negedge clk); retReq = 0; reqUnd = 0; wrEn = 0; wrMask = 0;
    chk("R8 exception wins", pcValue, 32'h0000_0004);
    chk("R11 write dropped on entry", psr, 32'hA000_009B);
    chk("R5 spsr from user", spsrData, 32'hA000_0010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule